// File: doc/BRIEF.md
# Signed-Count Bidirectional Shifter, 40-bit

This block shifts a 40-bit operand in either direction in a single pass. One signed count gives both the direction and the distance. A positive count shifts right. A negative count shifts left. A count of zero passes the operand through unchanged. A right shift fills from the top with either copies of bit 39 (arithmetic) or zeros (logical), as a mode input selects. The distance is limited to 16 positions. A count with a larger magnitude is clamped to 16 and keeps its direction.

The operand comes from one of two 40-bit accumulators or from a 16-bit data-bus word. A bus word is placed in the 40-bit field according to the direction, so the bits shifted out of the 16-bit window stay in the field. For a right shift the word occupies bits 31:16, and bits 39:32 carry its sign or zeros. For a left shift, or a zero count, the word occupies bits 15:0. The full 40-bit shifted field is presented for accumulator use. A 16-bit result is cut from the same window the word was placed in.

The block registers its results once. Each accepted request produces its outputs on the following clock edge. Nothing is written back to the accumulators or registers here.

Top module: `bshift40_top`

## Requirements
- R1: A shift count of zero returns the selected operand unchanged: all 40 accumulator bits on `acc_result`, or the bus word on `bus_result`.
- R2: A positive count shifts the 40-bit field right by that many positions, and a negative count shifts it left by its magnitude; a left shift fills bit 0 upward with zeros and discards bits pushed past bit 39.
- R3: For a right shift, `arith_mode`=1 fills the vacated upper bits with the field's bit 39 and `arith_mode`=0 fills them with zeros; a left shift gives the same result for either value of `arith_mode`.
- R4: A count whose magnitude exceeds 16 (count range -32..31, six-bit two's complement) is treated as 16 in the same direction.
- R5: `src_sel` picks the operand: 2'b00 selects `acc_a`, 2'b01 selects `acc_b`, and 2'b10 or 2'b11 selects `bus_word`.
- R6: For a right shift of a bus word, the word sits in bits 31:16 and bits 39:32 hold its bit 15 when `arith_mode`=1 (zeros when 0); `bus_result` is bits 31:16 of the shifted field.
- R7: For a left shift or a zero count of a bus word, the word sits in bits 15:0 with all higher bits zero; `bus_result` is bits 15:0 of the shifted field.
- R8: When `in_vld` is high at a clock edge, `out_vld` is high after that edge and both results reflect that request; when `in_vld` is low, `out_vld` drops and both results keep their previous values.
- R9: While `rst_n` is low, `out_vld`, `acc_result` and `bus_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe; inputs are captured on the edge it is high |
| src_sel | input | 2 | Operand source: 00 accumulator A, 01 accumulator B, 1x bus word |
| arith_mode | input | 1 | 1 = arithmetic right shift, 0 = logical right shift |
| shift_amt | input | 6 | Signed count; positive shifts right, negative shifts left |
| acc_a | input | 40 | Accumulator A operand |
| acc_b | input | 40 | Accumulator B operand |
| bus_word | input | 16 | Data-bus operand |
| out_vld | output | 1 | Results are from the request of the previous edge |
| acc_result | output | 40 | Shifted 40-bit field |
| bus_result | output | 16 | 16-bit window of the shifted field for bus operands |

## Verification
Every result of this block is due exactly one clock edge after the request is captured. The bench changes its inputs on the falling edge. It lets one rising edge pass and then reads `acc_result`, `bus_result` and `out_vld` on the next falling edge, so each value is taken half a period after the edge that produced it. The hold checks drop `in_vld`, change the operand, let one rising edge pass, and compare against the value already captured. This shows that neither result moves when no request is made. Reset values are read while reset is still held, before any rising edge can load a request.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  // Operand source encodings carried on src_sel.
  typedef enum logic [1:0] {
    SRC_ACC_A   = 2'b00,
    SRC_ACC_B   = 2'b01,
    SRC_BUS     = 2'b10,
    SRC_BUS_ALT = 2'b11
  } src_sel_e;

  // Shift direction decoded from the sign of the count.
  typedef enum logic [1:0] {
    DIR_NONE  = 2'b00,
    DIR_RIGHT = 2'b01,
    DIR_LEFT  = 2'b10
  } dir_e;

endpackage

// File: rtl/bshift_count_dec.sv
module bshift_count_dec
  import bshift_pkg::*;
#(
  parameter int CW     = 6,
  parameter int MAX_SH = 16,
  parameter int SW     = 5
) (
  input  logic signed [CW-1:0] amt,
  output dir_e                 dir,
  output logic [SW-1:0]        mag
);

  localparam int EW = CW + 1;

  // Magnitude limit: anything past MAX_SH becomes MAX_SH.
  function automatic logic [SW-1:0] clamp_mag(input logic [EW-1:0] m);
    if (m > EW'(MAX_SH)) return SW'(MAX_SH);
    return m[SW-1:0];
  endfunction

  logic [EW-1:0] amt_ext;
  logic [EW-1:0] amt_neg;

  assign amt_ext = {amt[CW-1], amt};
  assign amt_neg = EW'(0) - amt_ext;

  always_comb begin
    if (amt == '0) begin
      dir = DIR_NONE;
      mag = '0;
    end else if (amt[CW-1]) begin
      dir = DIR_LEFT;
      mag = clamp_mag(amt_neg);
    end else begin
      dir = DIR_RIGHT;
      mag = clamp_mag(amt_ext);
    end
  end

endmodule

// File: rtl/bshift_align.sv
module bshift_align
  import bshift_pkg::*;
#(
  parameter int DW = 40,
  parameter int BW = 16
) (
  input  logic [1:0]    src_sel,
  input  logic          arith,
  input  dir_e          dir,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [BW-1:0] bus_word,
  output logic [DW-1:0] field,
  output logic          is_bus
);

  localparam int XW = DW - 2 * BW;

  // Right-shift placement: word in the middle window, guard bits extended.
  function automatic logic [DW-1:0] place_right(input logic [BW-1:0] w, input logic ext);
    return {{XW{ext & w[BW-1]}}, w, {BW{1'b0}}};
  endfunction

  // Left-shift / pass placement: word in the bottom window.
  function automatic logic [DW-1:0] place_left(input logic [BW-1:0] w);
    return {{(DW-BW){1'b0}}, w};
  endfunction

  assign is_bus = src_sel[1];

  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_ACC_A: field = acc_a;
      SRC_ACC_B: field = acc_b;
      default:   field = (dir == DIR_RIGHT) ? place_right(bus_word, arith)
                                            : place_left(bus_word);
    endcase
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int DW = 40,
  parameter int SW = 5
) (
  input  logic [DW-1:0] field_in,
  input  dir_e          dir,
  input  logic [SW-1:0] mag,
  input  logic          arith,
  output logic [DW-1:0] field_out
);

  logic          fill_bit;
  logic [DW-1:0] stg [0:SW];

  assign fill_bit = arith & field_in[DW-1] & (dir == DIR_RIGHT);
  assign stg[0]   = field_in;

  // One power-of-two stage per bit of the magnitude.
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [DW-1:0] rsh;
    logic [DW-1:0] lsh;
    if (D < DW) begin : g_part
      assign rsh = {{D{fill_bit}}, stg[k][DW-1:D]};
      assign lsh = {stg[k][DW-1-D:0], {D{1'b0}}};
    end else begin : g_full
      assign rsh = {DW{fill_bit}};
      assign lsh = '0;
    end
    assign stg[k+1] = !mag[k] ? stg[k] : ((dir == DIR_RIGHT) ? rsh : lsh);
  end

  assign field_out = stg[SW];

endmodule

// File: rtl/bshift_extract.sv
module bshift_extract
  import bshift_pkg::*;
#(
  parameter int DW = 40,
  parameter int BW = 16
) (
  input  logic [DW-1:0] field,
  input  dir_e          dir,
  output logic [BW-1:0] bus_res
);

  // Window choice mirrors the placement chosen by the aligner.
  function automatic logic [BW-1:0] pick_window(input logic [DW-1:0] f, input logic right);
    return right ? f[2*BW-1:BW] : f[BW-1:0];
  endfunction

  assign bus_res = pick_window(field, dir == DIR_RIGHT);

endmodule

// File: rtl/bshift40_top.sv
module bshift40_top
  import bshift_pkg::*;
#(
  parameter int DW     = 40,
  parameter int BW     = 16,
  parameter int CW     = 6,
  parameter int MAX_SH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [1:0]           src_sel,
  input  logic                 arith_mode,
  input  logic signed [CW-1:0] shift_amt,
  input  logic [DW-1:0]        acc_a,
  input  logic [DW-1:0]        acc_b,
  input  logic [BW-1:0]        bus_word,
  output logic                 out_vld,
  output logic [DW-1:0]        acc_result,
  output logic [BW-1:0]        bus_result
);

  localparam int SW = $clog2(MAX_SH + 1);

  dir_e          dec_dir;
  logic [SW-1:0] dec_mag;
  logic [DW-1:0] aligned;
  logic          src_is_bus;
  logic [DW-1:0] shifted;
  logic [BW-1:0] bus_pick;

  bshift_count_dec #(.CW(CW), .MAX_SH(MAX_SH), .SW(SW)) u_dec (
    .amt (shift_amt),
    .dir (dec_dir),
    .mag (dec_mag)
  );

  bshift_align #(.DW(DW), .BW(BW)) u_align (
    .src_sel  (src_sel),
    .arith    (arith_mode),
    .dir      (dec_dir),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .bus_word (bus_word),
    .field    (aligned),
    .is_bus   (src_is_bus)
  );

  bshift_core #(.DW(DW), .SW(SW)) u_core (
    .field_in  (aligned),
    .dir       (dec_dir),
    .mag       (dec_mag),
    .arith     (arith_mode),
    .field_out (shifted)
  );

  bshift_extract #(.DW(DW), .BW(BW)) u_extract (
    .field   (shifted),
    .dir     (dec_dir),
    .bus_res (bus_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      acc_result <= '0;
      bus_result <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        acc_result <= shifted;
        bus_result <= src_is_bus ? bus_pick : shifted[BW-1:0];
      end
    end
  end

endmodule

// File: rtl/bshift40_chk.sv
module bshift40_chk
  import bshift_pkg::*;
#(
  parameter int DW     = 40,
  parameter int BW     = 16,
  parameter int CW     = 6,
  parameter int MAX_SH = 16,
  parameter int SW     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_vld,
  input logic [1:0]           src_sel,
  input logic                 arith_mode,
  input logic signed [CW-1:0] shift_amt,
  input logic [DW-1:0]        acc_a,
  input logic [DW-1:0]        acc_b,
  input logic [BW-1:0]        bus_word,
  input dir_e                 dec_dir,
  input logic [SW-1:0]        dec_mag,
  input logic                 out_vld,
  input logic [DW-1:0]        acc_result,
  input logic [BW-1:0]        bus_result
);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R8

  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(acc_result) && $stable(bus_result))); // R8

  AST_ZERO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && shift_amt == '0) |-> (dec_dir == DIR_NONE && dec_mag == '0)); // R1

  AST_ZERO_ACC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && shift_amt == '0 && src_sel == 2'b00) |=> (acc_result == $past(acc_a))); // R1

  AST_ZERO_BUS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && shift_amt == '0 && src_sel[1]) |=> (bus_result == $past(bus_word))); // R1

  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (shift_amt > CW'(MAX_SH) || shift_amt < -CW'(MAX_SH))) |-> (dec_mag == SW'(MAX_SH))); // R4

  AST_LOGICAL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !arith_mode && shift_amt > 0 && !src_sel[1]) |=> (acc_result[DW-1] == 1'b0)); // R3

  AST_ARITH_TOP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && arith_mode && shift_amt > 0 && !src_sel[1])
      |=> (acc_result[DW-1] == $past(src_sel[0] ? acc_b[DW-1] : acc_a[DW-1]))); // R3

  AST_LEFT_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && shift_amt < 0) |=> (acc_result[0] == 1'b0)); // R2

endmodule

bind bshift40_top bshift40_chk #(
  .DW(DW), .BW(BW), .CW(CW), .MAX_SH(MAX_SH), .SW($clog2(MAX_SH + 1))
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .src_sel    (src_sel),
  .arith_mode (arith_mode),
  .shift_amt  (shift_amt),
  .acc_a      (acc_a),
  .acc_b      (acc_b),
  .bus_word   (bus_word),
  .dec_dir    (dec_dir),
  .dec_mag    (dec_mag),
  .out_vld    (out_vld),
  .acc_result (acc_result),
  .bus_result (bus_result)
);

// File: tb/test_bshift40_top.sv
`timescale 1ns/100ps
module test_bshift40_top;

  typedef struct packed {
    logic [1:0]         src;
    logic               arith;
    logic signed [5:0]  amt;
    logic [39:0]        a;
    logic [39:0]        b;
    logic [15:0]        bus;
    logic [39:0]        exp;
    logic [3:0]         req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b1,  6'sd4,  40'h80_0000_0010, 40'h0, 16'h0,    40'hF8_0000_0001, 4'd3}, // R3 arithmetic right
    '{2'b00, 1'b0,  6'sd4,  40'h80_0000_0010, 40'h0, 16'h0,    40'h08_0000_0001, 4'd3}, // R3 logical right
    '{2'b01, 1'b1, -6'sd8,  40'hFF_FFFF_FFFF, 40'h00_1234_5678, 16'h0, 40'h12_3456_7800, 4'd5}, // R5 picks B, R2 left
    '{2'b01, 1'b0, -6'sd16, 40'h0, 40'hFF_0000_ABCD, 16'h0,    40'h00_ABCD_0000, 4'd2}, // R2 left by 16
    '{2'b00, 1'b1,  6'sd20, 40'h80_1234_0000, 40'h0, 16'h0,    40'hFF_FF80_1234, 4'd4}, // R4 clamp right
    '{2'b00, 1'b0, -6'sd31, 40'h00_0000_00FF, 40'h0, 16'h0,    40'h00_00FF_0000, 4'd4}, // R4 clamp left
    '{2'b10, 1'b1,  6'sd4,  40'h0, 40'h0, 16'h8000,            40'h00_0000_F800, 4'd6}, // R6 bus arith right
    '{2'b10, 1'b0,  6'sd4,  40'h0, 40'h0, 16'h8000,            40'h00_0000_0800, 4'd6}, // R6 bus logical right
    '{2'b10, 1'b1, -6'sd4,  40'h0, 40'h0, 16'h1234,            40'h00_0000_2340, 4'd7}, // R7 bus left
    '{2'b11, 1'b1,  6'sd0,  40'h0, 40'h0, 16'hBEEF,            40'h00_0000_BEEF, 4'd1}, // R1 bus pass
    '{2'b00, 1'b1,  6'sd0,  40'hA5_5A5A_A5A5, 40'h0, 16'h0,    40'hA5_5A5A_A5A5, 4'd1}, // R1 acc pass
    '{2'b10, 1'b1,  6'sd16, 40'h0, 40'h0, 16'h7FFF,            40'h00_0000_0000, 4'd6}, // R6 positive out
    '{2'b10, 1'b1,  6'sd16, 40'h0, 40'h0, 16'h8001,            40'h00_0000_FFFF, 4'd6}, // R6 negative out
    '{2'b01, 1'b1, -6'sd1,  40'h0, 40'h80_0000_0001, 16'h0,    40'h00_0000_0002, 4'd3}, // R3 mode ignored left
    '{2'b00, 1'b1,  6'sd1,  40'h7F_FFFF_FFFF, 40'h0, 16'h0,    40'h3F_FFFF_FFFF, 4'd2}, // R2 right by one
    '{2'b10, 1'b0,  6'sd20, 40'h0, 40'h0, 16'h8001,            40'h00_0000_0000, 4'd4}  // R4 bus clamp
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_vld = 1'b0;
  logic [1:0]        src_sel = 2'b00;
  logic              arith_mode = 1'b0;
  logic signed [5:0] shift_amt = '0;
  logic [39:0]       acc_a = '0;
  logic [39:0]       acc_b = '0;
  logic [15:0]       bus_word = '0;
  logic              out_vld;
  logic [39:0]       acc_result;
  logic [15:0]       bus_result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bshift40_top i_bshift40_top (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_sel(src_sel),
    .arith_mode(arith_mode), .shift_amt(shift_amt), .acc_a(acc_a),
    .acc_b(acc_b), .bus_word(bus_word), .out_vld(out_vld),
    .acc_result(acc_result), .bus_result(bus_result)
  );

  task automatic chk40(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent reference: signed shift operators on the whole value.
  function automatic logic [39:0] ref_acc(input logic [39:0] op, input int amt, input bit ar);
    int n;
    n = (amt > 16) ? 16 : ((amt < -16) ? -16 : amt);
    if (n > 0) return ar ? 40'($signed(op) >>> n) : (op >> n);
    return op << (-n);
  endfunction

  function automatic logic [15:0] ref_bus(input logic [15:0] w, input int amt, input bit ar);
    int n;
    logic signed [31:0] sx;
    n = (amt > 16) ? 16 : ((amt < -16) ? -16 : amt);
    sx = ar ? 32'($signed(w)) : {16'h0, w};
    if (n > 0) return 16'(sx >>> n);
    return 16'(w << (-n));
  endfunction

  task automatic apply(input logic [1:0] s, input logic ar, input logic signed [5:0] amt,
                       input logic [39:0] a, input logic [39:0] b, input logic [15:0] w);
    @(negedge clk);
    src_sel = s; arith_mode = ar; shift_amt = amt;
    acc_a = a; acc_b = b; bus_word = w; in_vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [39:0] held_acc;
    logic [15:0] held_bus;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk40("R9 out_vld", {39'h0, out_vld}, 40'h0);
    chk40("R9 acc_result", acc_result, 40'h0);
    chk40("R9 bus_result", {24'h0, bus_result}, 40'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].src, TBL[i].arith, TBL[i].amt, TBL[i].a, TBL[i].b, TBL[i].bus);
      chk40($sformatf("R8 out_vld row %0d", i), {39'h0, out_vld}, 40'h1);
      if (TBL[i].src[1])
        chk40($sformatf("R%0d bus row %0d", TBL[i].req, i), {24'h0, bus_result}, TBL[i].exp);
      else
        chk40($sformatf("R%0d acc row %0d", TBL[i].req, i), acc_result, TBL[i].exp);
    end

    // R8 idle: results hold, out_vld drops, operand change is ignored
    held_acc = acc_result;
    held_bus = bus_result;
    in_vld = 1'b0;
    acc_a = 40'h12_3456_789A;
    bus_word = 16'h5555;
    @(negedge clk);
    chk40("R8 idle out_vld", {39'h0, out_vld}, 40'h0);
    chk40("R8 idle acc hold", acc_result, held_acc);
    chk40("R8 idle bus hold", {24'h0, bus_result}, {24'h0, held_bus});

    // R2 R3 R4 R5 sweep of every count, both modes, against the reference
    for (int m = 0; m < 2; m++) begin
      for (int c = -32; c < 32; c++) begin
        apply(2'b01, m[0], 6'(c), 40'h0, 40'hC3_9A5E_0F71, 16'h0);
        chk40($sformatf("R2 sweep acc c=%0d m=%0d", c, m), acc_result,
              ref_acc(40'hC3_9A5E_0F71, c, m[0]));
        apply(2'b10, m[0], 6'(c), 40'h0, 40'h0, 16'h9C35);
        chk40($sformatf("R6 R7 sweep bus c=%0d m=%0d", c, m), {24'h0, bus_result},
              {24'h0, ref_bus(16'h9C35, c, m[0])});
      end
    end

    // R9 reset in mid-run clears outputs
    apply(2'b00, 1'b0, 6'sd0, 40'hFF_FFFF_FFFF, 40'h0, 16'hFFFF);
    in_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    chk40("R9 mid-run acc clear", acc_result, 40'h0);
    chk40("R9 mid-run vld clear", {39'h0, out_vld}, 40'h0);
    @(negedge clk);
    rst_n = 1'b1;
    finish_run();
  end

endmodule